// File: doc/BRIEF.md
# Parallel-Evaluate Arithmetic Logic Unit

This block is a 32-bit integer arithmetic logic unit for a datapath. On every clock edge it takes two operands, an operation code and a 5-bit shift amount. It computes the sum or difference, the three bitwise results, the inversion and the three shifts at the same time. An operation-code multiplexer picks one of them, and the chosen result goes into an output register together with a carry flag and a signed-overflow flag.

Add and subtract share one adder. For subtraction the second operand is inverted and the carry-in is forced high. All three shifts come from logarithmic shifters, one mux stage per shift-amount bit. The three shifts differ only in their direction and in the bit that fills the vacated positions.

Operation codes (4 bits): 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 NOT, 6 shift left, 7 logical shift right, 8 arithmetic shift right. Codes 9 to 15 are unused.

Top module: `alu_core`

## Requirements
- R1: Outputs are registered. Inputs sampled at a rising edge appear on the outputs after that edge. While rst_ni is low, result_o, carry_o and ovf_o are all 0.
- R2: Code 0 gives result_o = (a_i + b_i) mod 2^32, and carry_o is bit 32 of the unsigned sum.
- R3: Code 1 gives result_o = (a_i - b_i) mod 2^32, computed as a_i + ~b_i + 1. carry_o is bit 32 of that sum, so it is 1 exactly when a_i >= b_i unsigned.
- R4: For codes 0 and 1, ovf_o is 1 exactly when the two effective adder operands have the same sign and the sign of result_o differs from it.
- R5: Code 2 gives a_i & b_i, code 3 gives a_i | b_i, and code 4 gives a_i ^ b_i.
- R6: Code 5 gives ~a_i, and b_i has no effect on any output.
- R7: Code 6 shifts a_i left by shamt_i. Zeros fill the low bits, and bits shifted past bit 31 are lost.
- R8: Code 7 shifts a_i right by shamt_i with zeros filling the high bits.
- R9: Code 8 shifts a_i right by shamt_i with copies of a_i[31] filling the high bits.
- R10: For codes 6, 7 and 8, a shamt_i of 0 returns a_i unchanged. A shamt_i of 31 moves bit 0 to bit 31 (left shift) or bit 31 to bit 0 (right shifts).
- R11: For codes 2 to 8, carry_o and ovf_o are 0.
- R12: Codes 9 to 15 give result_o = 0, carry_o = 0 and ovf_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand, and the value shifted or inverted |
| b_i | input | 32 | Second operand |
| shamt_i | input | 5 | Shift amount |
| result_o | output | 32 | Registered result |
| carry_o | output | 1 | Registered adder carry-out |
| ovf_o | output | 1 | Registered signed overflow |

## Verification
There is only one register stage, so a fault shows at the outputs in the cycle right after the operands are sampled. It cannot stay hidden for more than that one cycle.

A stuck mux stage in a shifter shows only for shift amounts that have that bit set. A wrong fill bit shows only when the vacated positions should be nonzero, or should be zero under a set sign bit. For this reason the shift tests walk every single-bit amount and use operands with bit 31 both set and clear.

A wrong carry-in or a missing operand inversion on subtract shows at once as a result that is off by one, or as carry and overflow flags of the wrong polarity.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_NOT = 4'd5,
    OP_SLL = 4'd6,
    OP_SRL = 4'd7,
    OP_SRA = 4'd8
  } alu_op_e;

  typedef enum int {
    SH_LEFT  = 0,
    SH_LOGIC = 1,
    SH_ARITH = 2
  } shift_kind_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   total;

  // subtract: invert b and inject carry-in
  assign b_eff = b_i ^ {W{sub_i}};
  assign total = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};

  assign sum_o   = total[W-1:0];
  assign carry_o = total[W];
  assign ovf_o   = (a_i[W-1] == b_eff[W-1]) && (total[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu_log_shifter.sv
module alu_log_shifter
  import alu_pkg::*;
#(
  parameter int          W    = 32,
  parameter shift_kind_e KIND = SH_LEFT,
  localparam int         SW   = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [SW-1:0] amt_i,
  output logic [W-1:0]  data_o
);
  logic [SW:0][W-1:0] stg;
  logic               fill;

  assign fill   = (KIND == SH_ARITH) ? data_i[W-1] : 1'b0;
  assign stg[0] = data_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [W-1:0] moved;
    if (KIND == SH_LEFT) begin : g_l
      assign moved = {stg[k][W-1-S:0], {S{1'b0}}};
    end else begin : g_r
      assign moved = {{S{fill}}, stg[k][W-1:S]};
    end
    assign stg[k+1] = amt_i[k] ? moved : stg[k];
  end

  assign data_o = stg[SW];
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int  W  = 32,
  localparam int SW = $clog2(W)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [SW-1:0]   shamt_i,
  output logic [W-1:0]    result_o,
  output logic            carry_o,
  output logic            ovf_o
);
  localparam int NSH = 3;

  alu_op_e      op;
  logic [W-1:0] sum;
  logic         add_c, add_v;
  logic [W-1:0] sh_res [NSH];
  logic [W-1:0] res_d;
  logic         c_d, v_d;

  assign op = alu_op_e'(op_i);

  alu_addsub #(.W(W)) u_addsub (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (op == OP_SUB),
    .sum_o  (sum),
    .carry_o(add_c),
    .ovf_o  (add_v)
  );

  for (genvar g = 0; g < NSH; g++) begin : g_sh
    alu_log_shifter #(.W(W), .KIND(shift_kind_e'(g))) u_sh (
      .data_i(a_i),
      .amt_i (shamt_i),
      .data_o(sh_res[g])
    );
  end

  always_comb begin
    res_d = '0;
    c_d   = 1'b0;
    v_d   = 1'b0;
    case (op)
      OP_ADD, OP_SUB: begin
        res_d = sum;
        c_d   = add_c;
        v_d   = add_v;
      end
      OP_AND:  res_d = a_i & b_i;
      OP_OR:   res_d = a_i | b_i;
      OP_XOR:  res_d = a_i ^ b_i;
      OP_NOT:  res_d = ~a_i;
      OP_SLL:  res_d = sh_res[SH_LEFT];
      OP_SRL:  res_d = sh_res[SH_LOGIC];
      OP_SRA:  res_d = sh_res[SH_ARITH];
      default: res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      carry_o  <= 1'b0;
      ovf_o    <= 1'b0;
    end else begin
      result_o <= res_d;
      carry_o  <= c_d;
      ovf_o    <= v_d;
    end
  end
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
  import alu_pkg::*;
#(
  parameter int  W  = 32,
  localparam int SW = $clog2(W)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [OP_W-1:0] op_i,
  input logic [W-1:0]    a_i,
  input logic [W-1:0]    b_i,
  input logic [SW-1:0]   shamt_i,
  input logic [W-1:0]    result_o,
  input logic            carry_o,
  input logic            ovf_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_clear: assert (result_o == '0 && !carry_o && !ovf_o);
    end
  end

  a_r2_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_ADD |=> result_o == $past(a_i) + $past(b_i));

  a_r3_sub: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_SUB |=> result_o == $past(a_i) - $past(b_i));

  a_r6_not: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_NOT |=> result_o == ~$past(a_i));

  a_r10_zero_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i inside {OP_SLL, OP_SRL, OP_SRA} && shamt_i == '0) |=> result_o == $past(a_i));

  a_r11_no_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= OP_AND && op_i <= OP_SRA) |=> (!carry_o && !ovf_o));

  a_r12_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i > OP_SRA |=> (result_o == '0 && !carry_o && !ovf_o));
endmodule

bind alu_core alu_core_chk #(.W(W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .op_i    (op_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .shamt_i (shamt_i),
  .result_o(result_o),
  .carry_o (carry_o),
  .ovf_o   (ovf_o)
);

// File: tb/alu_core_tb_top.sv
module alu_core_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [4:0]  shamt_i = '0;
  logic [31:0] result_o;
  logic        carry_o, ovf_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  alu_core dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .shamt_i(shamt_i), .result_o(result_o), .carry_o(carry_o), .ovf_o(ovf_o)
  );

  task automatic chk(input string req, input logic [33:0] got, input logic [33:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] sh, output logic [31:0] r, output logic c, output logic v);
    logic [32:0] t;
    r = '0; c = 0; v = 0;
    case (op)
      4'd0: begin t = {1'b0, a} + {1'b0, b}; r = t[31:0]; c = t[32];
                  v = (a[31] == b[31]) && (r[31] != a[31]); end
      4'd1: begin t = {1'b0, a} + {1'b0, ~b} + 33'd1; r = t[31:0]; c = t[32];
                  v = (a[31] != b[31]) && (r[31] != a[31]); end
      4'd2: r = a & b;
      4'd3: r = a | b;
      4'd4: r = a ^ b;
      4'd5: r = ~a;
      4'd6: r = a << sh;
      4'd7: r = a >> sh;
      4'd8: r = $unsigned($signed(a) >>> sh);
      default: r = '0;
    endcase
  endtask

  // drive at falling edge, sample one time unit after the next rising edge
  task automatic run(input string req, input logic [3:0] op, input logic [31:0] a,
                     input logic [31:0] b, input logic [4:0] sh);
    logic [31:0] er; logic ec, ev;
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b; shamt_i = sh;
    @(posedge clk_i); #1;
    model(op, a, b, sh, er, ec, ev);
    chk(req, {ovf_o, carry_o, result_o}, {ev, ec, er});
  endtask

  task automatic t_reset;
    a_i = 32'hFFFF_FFFF; b_i = 32'h1; op_i = 4'd0;
    repeat (3) @(posedge clk_i);
    #1 chk("R1 reset", {ovf_o, carry_o, result_o}, 34'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1 first sample", {ovf_o, carry_o, result_o}, {1'b0, 1'b1, 32'h0});
  endtask

  task automatic t_add;
    run("R2 add", 4'd0, 32'd12, 32'd30, 5'd0);
    run("R2 add carry", 4'd0, 32'hFFFF_FFFF, 32'd1, 5'd0);
    run("R4 add ovf pos", 4'd0, 32'h7FFF_FFFF, 32'd1, 5'd0);
    run("R4 add ovf neg", 4'd0, 32'h8000_0000, 32'h8000_0000, 5'd0);
  endtask

  task automatic t_sub;
    run("R3 sub ge", 4'd1, 32'd50, 32'd8, 5'd0);
    run("R3 sub lt", 4'd1, 32'd8, 32'd50, 5'd0);
    run("R3 sub equal", 4'd1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 5'd0);
    run("R4 sub ovf", 4'd1, 32'h8000_0000, 32'd1, 5'd0);
    run("R4 sub ovf2", 4'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0);
  endtask

  task automatic t_logic;
    run("R5 and", 4'd2, 32'hF0F0_1234, 32'hFF00_FF00, 5'd3);
    run("R5 or", 4'd3, 32'hF0F0_1234, 32'h0F00_00FF, 5'd3);
    run("R5 xor", 4'd4, 32'hAAAA_5555, 32'hFFFF_0000, 5'd3);
    run("R6 not", 4'd5, 32'h1234_5678, 32'h0, 5'd0);
    run("R6 not b ignored", 4'd5, 32'h1234_5678, 32'hFFFF_FFFF, 5'd9);
  endtask

  task automatic t_shift;
    for (int k = 0; k < 5; k++) begin
      run("R7 sll", 4'd6, 32'h8123_4567, 32'h0, 5'(1 << k));
      run("R8 srl", 4'd7, 32'h8123_4567, 32'h0, 5'(1 << k));
      run("R9 sra neg", 4'd8, 32'h8123_4567, 32'h0, 5'(1 << k));
      run("R9 sra pos", 4'd8, 32'h4123_4567, 32'h0, 5'(1 << k));
    end
    run("R9 sra 3", 4'd8, 32'h9100_0000, 32'h0, 5'd3);
    run("R10 sll 0", 4'd6, 32'hC0DE_0001, 32'h0, 5'd0);
    run("R10 srl 0", 4'd7, 32'hC0DE_0001, 32'h0, 5'd0);
    run("R10 sra 0", 4'd8, 32'hC0DE_0001, 32'h0, 5'd0);
    run("R10 sll 31", 4'd6, 32'h0000_0001, 32'h0, 5'd31);
    run("R10 srl 31", 4'd7, 32'h8000_0000, 32'h0, 5'd31);
    run("R10 sra 31", 4'd8, 32'h8000_0000, 32'h0, 5'd31);
    run("R11 shift flags", 4'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd7);
  endtask

  task automatic t_unused;
    for (int c = 9; c < 16; c++)
      run("R12 unused", 4'(c), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd5);
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_shift();
    t_unused();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule